// File: doc/BRIEF.md
# DSP Modulo Address Generator

This block produces data-memory addresses for a DSP-style load/store path in the execute stage, and it updates the pointer registers that those addresses come from. It holds eight 32-bit address registers: six pointers (P2 to P7) and two index registers (P8 for the X side and single moves, P9 for the Y side). A load port writes any of them.

Each valid operation is one of two kinds. A dual move reads an X pointer (P4 or P5) and a Y pointer (P6 or P7) and presents both on two address buses. Each pointer then takes a no-update, a +2 step or an index add. One of the two pointers may run in a circular window: when its low 16 bits equal the window end, those bits reload with the window start and the upper bits are kept. A single move reads one pointer (P2 to P5) and supports no-update, post-increment, index add and pre-decrement, in word (2) or longword (4) steps.

Addresses and pointer updates are registered at the same clock edge. The address buses keep their values while no move is active.

Top module: `mag_modulo_agen`

## Requirements
- R1: After reset all eight address registers and the three address outputs read zero.
- R2: With `ld_en` high, `ld_data` is written at the next edge into the register chosen by `ld_sel` (0..7 select P2..P9). A load wins over a move update to the same register in the same cycle.
- R3: A valid move with `op_kind`=01 is a dual move. `x_sel` 0/1 picks P4/P5 and `y_sel` 0/1 picks P6/P7. After the edge, `x_addr` and `y_addr` hold the pointer values from before that edge's update.
- R4: In a dual move, a lane mode of 00 or 11 leaves the pointer as it is, 01 adds 2, and 10 adds P8 (X lane) or P9 (Y lane). The new value is written at the same edge as the bus address.
- R5: Modulo runs on the X lane only when `mod_x_en`=1 and `mod_y_en`=0. With `mod_y_en`=1 it runs on the Y lane, and the X lane is linear whatever `mod_x_en` is.
- R6: On a modulo lane doing a step (mode 01 or 10), a pointer whose bits [15:0] equal `mod_end` gets bits [15:0] reloaded with `mod_start`, with bits [31:16] kept. Any other pointer gets the full 32-bit step add.
- R7: On a modulo lane in mode 00 or 11, the pointer stays unchanged even when its low bits equal `mod_end`.
- R8: A valid move with `op_kind`=10 (word) or 11 (longword) is a single move. `s_sel` 0..3 picks P2..P5. With `s_mode` 00 (no-update), 01 (add 2 or 4) or 10 (add P8), `s_addr` gets the value from before the update.
- R9: With `s_mode`=11 a single move subtracts 2 (word) or 4 (longword) from the pointer, and `s_addr` gets the decremented value.
- R10: When `op_valid` is low or `op_kind`=00, all address outputs hold and no register changes except through the load port.
- R11: A single move never applies modulo wrap, whatever the modulo enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 00 none, 01 dual move, 10 single word, 11 single longword |
| x_sel | input | 1 | X pointer select (P4/P5) |
| x_mode | input | 2 | X lane mode |
| y_sel | input | 1 | Y pointer select (P6/P7) |
| y_mode | input | 2 | Y lane mode |
| s_sel | input | 2 | Single-move pointer select (P2..P5) |
| s_mode | input | 2 | Single-move mode |
| mod_x_en | input | 1 | Modulo request for the X lane |
| mod_y_en | input | 1 | Modulo request for the Y lane |
| mod_start | input | 16 | Circular window start (low bits) |
| mod_end | input | 16 | Circular window end (low bits) |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | 3 | Register to load (P2..P9) |
| ld_data | input | 32 | Load value |
| x_addr | output | 32 | X address bus |
| y_addr | output | 32 | Y address bus |
| s_addr | output | 32 | Single-move address bus |
| regs_o | output | 256 | All eight registers, P2 in bits [31:0] up to P9 in [255:224] |

## Verification
The bench builds the block with its default parameters: 32-bit registers and a 16-bit modulo field. The directed part keeps the circular window a few words wide around 0x0100 and loads pointers with varied upper halves. In this way every wrap shows whether the upper 16 bits are kept, and the index registers hold a negative value for the backward steps. The random part loads pointers inside or next to that window and sets the window end at several distances. End matches therefore happen often under every combination of modulo enables, lane modes and load collisions.

// File: rtl/mag_pkg.sv
package mag_pkg;
  typedef enum logic [1:0] {
    OPK_NONE = 2'b00,
    OPK_DUAL = 2'b01,
    OPK_SW   = 2'b10,
    OPK_SL   = 2'b11
  } opk_e;

  typedef enum logic [1:0] {
    AM_HOLD = 2'b00,
    AM_INC  = 2'b01,
    AM_IDX  = 2'b10,
    AM_DEC  = 2'b11
  } amode_e;

  localparam int unsigned NREG  = 8;
  localparam int unsigned IDX_X = 6;
  localparam int unsigned IDX_Y = 7;
endpackage

// File: rtl/mag_areg_file.sv
module mag_areg_file #(
  parameter int unsigned AW   = 32,
  parameter int unsigned NREG = 8,
  parameter int unsigned NWP  = 2,
  localparam int unsigned SW  = $clog2(NREG)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ld_en,
  input  logic [SW-1:0]       ld_sel,
  input  logic [AW-1:0]       ld_data,
  input  logic [NWP-1:0]      wp_en,
  input  logic [SW-1:0]       wp_sel [NWP],
  input  logic [AW-1:0]       wp_val [NWP],
  output logic [AW-1:0]       regs_q [NREG]
);

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic          hit_ld;
    logic [NWP-1:0] hit_wp;
    logic          en;
    logic [AW-1:0] d;

    always_comb begin
      hit_ld = ld_en && (ld_sel == SW'(r));
      for (int p = 0; p < NWP; p++) begin
        hit_wp[p] = wp_en[p] && (wp_sel[p] == SW'(r));
      end
      en = hit_ld || (|hit_wp);
      d  = regs_q[r];
      for (int p = 0; p < NWP; p++) begin
        if (hit_wp[p]) d = wp_val[p];
      end
      if (hit_ld) d = ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[r] <= '0;
      end else if (en) begin
        regs_q[r] <= d;
      end
    end
  end

  // R2: a load lands in the chosen register at the next edge
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> regs_q[$past(ld_sel)] == $past(ld_data));

  if (NWP > 1) begin : g_clash
    // R3: the two move write ports never aim at the same register
    assert_port_distinct_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_en[0] && wp_en[1]) |-> (wp_sel[0] != wp_sel[1]));
  end

endmodule

// File: rtl/mag_lane_step.sv
module mag_lane_step #(
  parameter int unsigned AW   = 32,
  parameter int unsigned MW   = 16,
  parameter int unsigned STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] idx,
  input  logic [1:0]    mode,
  input  logic          mod_on,
  input  logic [MW-1:0] mod_start,
  input  logic [MW-1:0] mod_end,
  output logic [AW-1:0] nxt
);
  import mag_pkg::*;

  amode_e        m;
  logic          adv;
  logic          at_end;
  logic [AW-1:0] delta;

  always_comb begin
    m      = amode_e'(mode);
    adv    = (m == AM_INC) || (m == AM_IDX);
    delta  = (m == AM_IDX) ? idx : AW'(STEP);
    at_end = (ptr[MW-1:0] == mod_end);
    if (!adv) begin
      nxt = ptr;
    end else if (mod_on && at_end) begin
      nxt = {ptr[AW-1:MW], mod_start};
    end else begin
      nxt = ptr + delta;
    end
  end

  // R6: an end match on a stepping modulo lane reloads the low field only
  assert_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_on && (mode == 2'b01 || mode == 2'b10) && ptr[MW-1:0] == mod_end)
      |-> (nxt[MW-1:0] == mod_start && nxt[AW-1:MW] == ptr[AW-1:MW]));

  // R7: a non-stepping mode keeps the pointer, modulo or not
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> nxt == ptr);

endmodule

// File: rtl/mag_single_step.sv
module mag_single_step #(
  parameter int unsigned AW    = 32,
  parameter int unsigned WSTEP = 2,
  parameter int unsigned LSTEP = 4
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] idx,
  input  logic [1:0]    mode,
  input  logic          is_long,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] nxt
);
  import mag_pkg::*;

  logic [AW-1:0] step;

  always_comb begin
    step = is_long ? AW'(LSTEP) : AW'(WSTEP);
    addr = ptr;
    nxt  = ptr;
    unique case (amode_e'(mode))
      AM_HOLD: nxt = ptr;
      AM_INC:  nxt = ptr + step;
      AM_IDX:  nxt = ptr + idx;
      AM_DEC: begin
        nxt  = ptr - step;
        addr = nxt;
      end
      default: nxt = ptr;
    endcase
  end

endmodule

// File: rtl/mag_modulo_agen.sv
module mag_modulo_agen #(
  parameter int unsigned AW = 32,
  parameter int unsigned MW = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         op_valid,
  input  logic [1:0]                   op_kind,
  input  logic                         x_sel,
  input  logic [1:0]                   x_mode,
  input  logic                         y_sel,
  input  logic [1:0]                   y_mode,
  input  logic [1:0]                   s_sel,
  input  logic [1:0]                   s_mode,
  input  logic                         mod_x_en,
  input  logic                         mod_y_en,
  input  logic [MW-1:0]                mod_start,
  input  logic [MW-1:0]                mod_end,
  input  logic                         ld_en,
  input  logic [2:0]                   ld_sel,
  input  logic [AW-1:0]                ld_data,
  output logic [AW-1:0]                x_addr,
  output logic [AW-1:0]                y_addr,
  output logic [AW-1:0]                s_addr,
  output logic [mag_pkg::NREG*AW-1:0]  regs_o
);
  import mag_pkg::*;

  localparam int unsigned SW    = $clog2(NREG);
  localparam int unsigned NLANE = 2;
  localparam int unsigned NWP   = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  // register file
  logic [AW-1:0]  regs [NREG];
  logic [NWP-1:0] wp_en;
  logic [SW-1:0]  wp_sel [NWP];
  logic [AW-1:0]  wp_val [NWP];

  mag_areg_file #(.AW(AW), .NREG(NREG), .NWP(NWP)) u_regs (
    .clk     (clk),
    .rst_n   (rst_ni),
    .ld_en   (ld_en),
    .ld_sel  (ld_sel),
    .ld_data (ld_data),
    .wp_en   (wp_en),
    .wp_sel  (wp_sel),
    .wp_val  (wp_val),
    .regs_q  (regs)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_flat
    assign regs_o[r*AW +: AW] = regs[r];
  end

  // operation decode
  opk_e          kind;
  logic          fire, is_dual, is_single;
  logic [SW-1:0] xi, yi, si;
  logic          mod_x_on, mod_y_on;

  always_comb begin
    kind      = opk_e'(op_kind);
    fire      = op_valid && (kind != OPK_NONE);
    is_dual   = fire && (kind == OPK_DUAL);
    is_single = fire && (kind == OPK_SW || kind == OPK_SL);
    xi        = x_sel ? SW'(3) : SW'(2);
    yi        = y_sel ? SW'(5) : SW'(4);
    si        = SW'(s_sel);
    mod_y_on  = mod_y_en;
    mod_x_on  = mod_x_en && !mod_y_en;
  end

  // dual-move lanes: 0 is X, 1 is Y
  logic [AW-1:0] lane_ptr  [NLANE];
  logic [AW-1:0] lane_idx  [NLANE];
  logic [1:0]    lane_mode [NLANE];
  logic          lane_on   [NLANE];
  logic [AW-1:0] lane_nxt  [NLANE];

  always_comb begin
    lane_ptr[0]  = regs[xi];
    lane_idx[0]  = regs[IDX_X];
    lane_mode[0] = x_mode;
    lane_on[0]   = mod_x_on;
    lane_ptr[1]  = regs[yi];
    lane_idx[1]  = regs[IDX_Y];
    lane_mode[1] = y_mode;
    lane_on[1]   = mod_y_on;
  end

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    mag_lane_step #(.AW(AW), .MW(MW), .STEP(2)) u_lane (
      .clk       (clk),
      .rst_n     (rst_ni),
      .ptr       (lane_ptr[g]),
      .idx       (lane_idx[g]),
      .mode      (lane_mode[g]),
      .mod_on    (lane_on[g]),
      .mod_start (mod_start),
      .mod_end   (mod_end),
      .nxt       (lane_nxt[g])
    );
  end

  // single-move path
  logic [AW-1:0] s_ptr, s_bus, s_nxt;

  assign s_ptr = regs[si];

  mag_single_step #(.AW(AW), .WSTEP(2), .LSTEP(4)) u_single (
    .ptr     (s_ptr),
    .idx     (regs[IDX_X]),
    .mode    (s_mode),
    .is_long (kind == OPK_SL),
    .addr    (s_bus),
    .nxt     (s_nxt)
  );

  // write-back ports
  always_comb begin
    wp_en[0]  = is_dual || is_single;
    wp_sel[0] = is_dual ? xi : si;
    wp_val[0] = is_dual ? lane_nxt[0] : s_nxt;
    wp_en[1]  = is_dual;
    wp_sel[1] = yi;
    wp_val[1] = lane_nxt[1];
  end

  // address bus registers: next state, then registers with enables
  logic [AW-1:0] x_addr_d, y_addr_d, s_addr_d;
  logic          xy_en, s_en;

  always_comb begin
    xy_en    = is_dual;
    s_en     = is_single;
    x_addr_d = lane_ptr[0];
    y_addr_d = lane_ptr[1];
    s_addr_d = s_bus;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      x_addr <= '0;
      y_addr <= '0;
    end else if (xy_en) begin
      x_addr <= x_addr_d;
      y_addr <= y_addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      s_addr <= '0;
    end else if (s_en) begin
      s_addr <= s_addr_d;
    end
  end

  // R4: a linear X increment leaves the pointer two above the presented address
  assert_x_linear_inc_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_dual && x_mode == 2'b01 && !mod_x_on && !ld_en)
      |=> regs[$past(xi)] == x_addr + AW'(2));

  // R5: with Y modulo requested, the X lane steps linearly even at the end value
  assert_x_linear_under_y_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_dual && mod_y_en && x_mode == 2'b01 && !ld_en)
      |=> regs[$past(xi)] == x_addr + AW'(2));

  // R8: a post-increment word move presents the old value
  assert_post_inc_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_single && kind == OPK_SW && s_mode == 2'b01 && !ld_en)
      |=> regs[$past(si)] == s_addr + AW'(2));

  // R9: a pre-decrement move presents the value it leaves in the pointer
  assert_pre_dec_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (is_single && s_mode == 2'b11 && !ld_en) |=> s_addr == regs[$past(si)]);

  // R10: no active move, no bus change
  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    !fire |=> ($stable(x_addr) && $stable(y_addr) && $stable(s_addr)));

endmodule

// File: tb/mag_modulo_agen_bench.sv
`timescale 1ns/1ps
module mag_modulo_agen_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic        x_sel, y_sel;
  logic [1:0]  x_mode, y_mode, s_sel, s_mode;
  logic        mod_x_en, mod_y_en;
  logic [15:0] mod_start, mod_end;
  logic        ld_en;
  logic [2:0]  ld_sel;
  logic [31:0] ld_data;
  logic [31:0] x_addr, y_addr, s_addr;
  logic [255:0] regs_o;

  always #5 clk = ~clk;

  mag_modulo_agen u_mag_modulo_agen (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .x_sel(x_sel), .x_mode(x_mode), .y_sel(y_sel), .y_mode(y_mode),
    .s_sel(s_sel), .s_mode(s_mode), .mod_x_en(mod_x_en), .mod_y_en(mod_y_en),
    .mod_start(mod_start), .mod_end(mod_end), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_data(ld_data), .x_addr(x_addr), .y_addr(y_addr), .s_addr(s_addr),
    .regs_o(regs_o)
  );

  int    n_checks = 0;
  int    n_errors = 0;
  bit    done = 0;

  logic [31:0] m_reg [8];
  logic [31:0] m_x, m_y, m_s;
  string       t_reg [8];
  string       t_x, t_y, t_s;

  function automatic logic [31:0] get_reg(int r);
    return regs_o[r*32 +: 32];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(t_x, "x_addr", x_addr, m_x);
    chk(t_y, "y_addr", y_addr, m_y);
    chk(t_s, "s_addr", s_addr, m_s);
    for (int r = 0; r < 8; r++) chk(t_reg[r], $sformatf("P%0d", r + 2), get_reg(r), m_reg[r]);
  endtask

  // lane step as the requirements state it; returns tag through ref
  function automatic logic [31:0] lane_ref(logic [31:0] p, logic [31:0] ix, logic [1:0] md,
                                           bit modon, output string tag);
    logic [31:0] d;
    if (md == 2'b01) d = 32'd2;
    else if (md == 2'b10) d = ix;
    else begin
      tag = modon ? "R7" : "R4";
      return p;
    end
    if (modon && p[15:0] == mod_end) begin
      tag = "R6";
      return {p[31:16], mod_start};
    end
    tag = modon ? "R5" : "R4";
    return p + d;
  endfunction

  task automatic model_apply();
    logic [31:0] n [8];
    string       tg;
    int          xi, yi, si, st;
    bit          fire;
    for (int r = 0; r < 8; r++) n[r] = m_reg[r];
    fire = op_valid && (op_kind != 2'b00);
    if (!fire) begin
      t_x = "R10"; t_y = "R10"; t_s = "R10";
      for (int r = 0; r < 8; r++) t_reg[r] = "R10";
    end
    if (fire && op_kind == 2'b01) begin
      xi = x_sel ? 3 : 2;
      yi = y_sel ? 5 : 4;
      m_x = m_reg[xi]; m_y = m_reg[yi];
      t_x = "R3"; t_y = "R3";
      n[xi] = lane_ref(m_reg[xi], m_reg[6], x_mode, mod_x_en && !mod_y_en, tg);
      t_reg[xi] = tg;
      n[yi] = lane_ref(m_reg[yi], m_reg[7], y_mode, mod_y_en, tg);
      t_reg[yi] = tg;
    end
    if (fire && op_kind[1]) begin
      si = int'(s_sel);
      st = op_kind[0] ? 4 : 2;
      t_reg[si] = (mod_x_en || mod_y_en) ? "R11" : "R8";
      t_s = "R8";
      case (s_mode)
        2'b00: begin m_s = m_reg[si]; end
        2'b01: begin m_s = m_reg[si]; n[si] = m_reg[si] + 32'(st); end
        2'b10: begin m_s = m_reg[si]; n[si] = m_reg[si] + m_reg[6]; end
        default: begin
          n[si] = m_reg[si] - 32'(st); m_s = n[si];
          t_s = "R9"; t_reg[si] = "R9";
        end
      endcase
    end
    if (ld_en) begin
      n[ld_sel] = ld_data;
      t_reg[ld_sel] = "R2";
    end
    for (int r = 0; r < 8; r++) m_reg[r] = n[r];
  endtask

  task automatic step();
    model_apply();
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    op_valid = 0; op_kind = 2'b00; ld_en = 0;
  endtask

  task automatic load(int r, logic [31:0] v);
    idle();
    ld_en = 1; ld_sel = 3'(r); ld_data = v;
    step();
    ld_en = 0;
  endtask

  task automatic dual(bit xs, logic [1:0] xm, bit ys, logic [1:0] ym, bit mx, bit my);
    idle();
    op_valid = 1; op_kind = 2'b01;
    x_sel = xs; x_mode = xm; y_sel = ys; y_mode = ym;
    mod_x_en = mx; mod_y_en = my;
    step();
  endtask

  task automatic single(bit lng, logic [1:0] sel, logic [1:0] md, bit mx, bit my);
    idle();
    op_valid = 1; op_kind = lng ? 2'b11 : 2'b10;
    s_sel = sel; s_mode = md; mod_x_en = mx; mod_y_en = my;
    step();
  endtask

  initial begin
    rst_n = 0;
    op_valid = 0; op_kind = 0; x_sel = 0; y_sel = 0; x_mode = 0; y_mode = 0;
    s_sel = 0; s_mode = 0; mod_x_en = 0; mod_y_en = 0;
    mod_start = 16'h0100; mod_end = 16'h0106;
    ld_en = 0; ld_sel = 0; ld_data = 0;
    for (int r = 0; r < 8; r++) begin m_reg[r] = 0; t_reg[r] = "R1"; end
    m_x = 0; m_y = 0; m_s = 0; t_x = "R1"; t_y = "R1"; t_s = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1: reset state seen at the ports
    compare_all();
    for (int r = 0; r < 8; r++) begin t_reg[r] = "R10"; end
    t_x = "R10"; t_y = "R10"; t_s = "R10";

    // R2: load all registers
    load(0, 32'h0000_1000); load(1, 32'h0000_2000);
    load(2, 32'hABCD_0100); load(3, 32'h0000_3000);
    load(4, 32'h5555_0104); load(5, 32'h0000_7000);
    load(6, 32'h0000_0010); load(7, 32'hFFFF_FFFE);

    // R3 / R4: linear dual moves on P5 and P7
    dual(1, 2'b01, 1, 2'b01, 0, 0);
    dual(1, 2'b10, 1, 2'b10, 0, 0);
    dual(1, 2'b00, 1, 2'b11, 0, 0);

    // R6: X modulo wrap on P4, upper half kept
    for (int i = 0; i < 4; i++) dual(0, 2'b01, 1, 2'b01, 1, 0);
    chk("R6", "P4 after wrap", get_reg(2), 32'hABCD_0100);

    // R5: both enables set; Y wraps on P6, X stays linear
    dual(0, 2'b01, 0, 2'b01, 1, 1);
    dual(0, 2'b01, 0, 2'b01, 1, 1);
    chk("R5", "P6 after Y wrap", get_reg(4), 32'h5555_0100);

    // R7: modulo lane in no-update mode at the end value
    load(2, 32'h1234_0106);
    dual(0, 2'b00, 0, 2'b11, 1, 0);
    chk("R7", "P4 frozen at end", get_reg(2), 32'h1234_0106);

    // R9: longword pre-decrement on P3
    single(1, 2'd1, 2'b11, 0, 0);
    chk("R9", "s_addr predec", s_addr, 32'h0000_1FFC);
    // R8: single post modes, word and long
    single(0, 2'd0, 2'b01, 0, 0);
    single(1, 2'd0, 2'b01, 0, 0);
    single(0, 2'd3, 2'b10, 0, 0);
    single(1, 2'd2, 2'b00, 0, 0);
    single(0, 2'd1, 2'b11, 0, 0);
    // R11: single move on a pointer at the window end stays linear
    single(0, 2'd2, 2'b01, 1, 1);
    chk("R11", "P4 linear single", get_reg(2), 32'h1234_0108);

    // R10: strobe low and kind none
    idle(); op_kind = 2'b01; x_mode = 2'b01; step();
    op_valid = 1; op_kind = 2'b00; step();

    // R2: load colliding with a move update on P5
    idle();
    op_valid = 1; op_kind = 2'b01; x_sel = 1; x_mode = 2'b01; y_sel = 0; y_mode = 2'b01;
    mod_x_en = 0; mod_y_en = 0;
    ld_en = 1; ld_sel = 3'd3; ld_data = 32'hCAFE_0000;
    step();
    chk("R2", "load wins", get_reg(3), 32'hCAFE_0000);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      if (i % 200 == 0) mod_end = 16'h0100 + 16'(2 * ($urandom % 6));
      op_valid = ($urandom % 4) != 0;
      op_kind  = 2'($urandom);
      x_sel = 1'($urandom); y_sel = 1'($urandom);
      x_mode = 2'($urandom); y_mode = 2'($urandom);
      s_sel = 2'($urandom); s_mode = 2'($urandom);
      mod_x_en = 1'($urandom); mod_y_en = 1'($urandom);
      ld_en = ($urandom % 4) == 0;
      ld_sel = 3'($urandom);
      if (ld_sel >= 3'd6)
        ld_data = ($urandom % 2) ? 32'(2 * ($urandom % 4)) : 32'hFFFF_FFFE;
      else
        ld_data = {16'($urandom), 16'h0100 + 16'(2 * ($urandom % 8))};
      step();
    end

    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule